// File: doc/BRIEF.md
# Synchronous Serial Port with Burst Buffer

This block is an 8-bit clocked serial shifter with one data output, one data input and one clock line. The clock line can be driven or received. As master, the port toggles its own shift clock on strobes from an external timer. A guard keeps each clock phase at least `HALF_MIN` system cycles long. As slave, the port follows an external clock that it passes through a two-flop synchroniser and an edge detector. Data leaves most significant bit first. The output bit changes only while the clock is low. The input bit is taken on each rising clock edge.

A 16-slot byte buffer holds the bytes for a transfer. Each slot is sent and then overwritten in place with the byte received in the same eight clocks. A single transfer moves slot 0 only. A burst moves slots 0 to N-1 back to back, with no software action between bytes, and raises the interrupt once, after the final byte. Software reaches the port through four byte-wide registers:

- Address 0, DATA: reads and writes the slot chosen by the select field.
- Address 1, CTRL: bit 0 selects master (1) or slave (0); bit 1 selects burst; bit 2 is a write-only go bit.
- Address 2, COUNT: bits [3:0] hold the index of the last burst slot; bits [7:4] select the slot that DATA reaches.
- Address 3, STAT: bit 0 is busy; bit 1 is byte done; bit 2 is end of transfer.

Top module: `sio_port`

## Requirements
- R1: After reset, sck_out=1, sck_oe=0, sdo=1, irq=0, and the STAT and COUNT registers read 0x00.
- R2: Each byte is shifted out MSB first. sdo is updated only on a falling clock edge, and it does not change while the line clock stays high.
- R3: sdi is sampled on each rising clock edge. The received byte replaces the buffer slot it was sent from and can be read through DATA.
- R4: In master mode each accepted tick toggles sck_out. A tick that arrives fewer than HALF_MIN cycles after the previous toggle is ignored, so every clock phase lasts at least HALF_MIN cycles (4 by default).
- R5: In master mode sck_out idles high after the last bit, and ticks have no effect while no transfer is active.
- R6: sck_oe equals CTRL bit 0 (1 = master, clock driven; 0 = slave, clock received).
- R7: Writing CTRL with bit 2 set and bit 1 clear transfers exactly one byte, from slot 0, whatever the COUNT value. At the end STAT reads 0x06 and irq is 1.
- R8: With CTRL bit 1 set, a transfer moves slots 0 to COUNT[3:0] in order (1 to 16 bytes). irq rises once, in the cycle in which busy falls after the last byte, and never between bytes.
- R9: In slave mode sck_in passes through two synchronising flops. sdo takes its new value three clock cycles after sck_in falls, and STAT bit 0 reads 1 from go until the last rising edge.
- R10: Writing STAT with 1 in bit 1 or bit 2 clears that flag only. irq equals STAT bit 2.
- R11: While busy, writes to DATA, CTRL and COUNT are ignored.
- R12: In slave mode, edges on sck_in before go leave sdo, the buffer and STAT unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 DATA, 1 CTRL, 2 COUNT, 3 STAT) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| tick | input | 1 | Timer overflow strobe for the master clock |
| sck_in | input | 1 | External shift clock (slave mode) |
| sck_out | output | 1 | Generated shift clock (master mode) |
| sck_oe | output | 1 | Clock pin drive enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | End-of-transfer interrupt, level |

## Verification
Four properties are checked on every cycle. sdo stays constant while the driven clock is high. Every master clock phase meets the minimum length. The master clock returns high once the port is idle. The interrupt rises only in the cycle in which busy falls.

Other behaviour shows only in the bench scenarios, because it depends on data and register contents:
- MSB-first order and the in-place swap of each slot.
- The three-cycle delay through the slave synchroniser.
- The one-byte limit of single mode.
- Burst lengths of 4 and 16 bytes.
- Writes that are dropped while busy.
- The write-one-to-clear status bits.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int BIT_W  = $clog2(DATA_W);

    localparam int CTRL_MASTER_BIT = 0;
    localparam int CTRL_BURST_BIT  = 1;
    localparam int CTRL_GO_BIT     = 2;
    localparam int STAT_DONE_BIT   = 1;
    localparam int STAT_END_BIT    = 2;

    typedef enum logic [1:0] {
        REG_DATA  = 2'd0,
        REG_CTRL  = 2'd1,
        REG_COUNT = 2'd2,
        REG_STAT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic burst;
        logic master;
    } ctrl_t;

    typedef struct packed {
        logic end_f;
        logic done_f;
        logic busy;
    } stat_t;

    function automatic logic [DATA_W-1:0] pack_stat(stat_t s);
        return {{(DATA_W-3){1'b0}}, s};
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(ctrl_t c);
        return {{(DATA_W-2){1'b0}}, c};
    endfunction

endpackage

// File: rtl/sio_clk_src.sv
module sio_clk_src
    import sio_pkg::*;
#(
    parameter int HALF_MIN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic master_i,
    input  logic active_i,
    input  logic tick_i,
    input  logic sck_in_i,
    output logic sck_o,
    output logic fall_o,
    output logic rise_o
);
    localparam int CW = $clog2(HALF_MIN + 1);

    logic [CW-1:0] gap_q;
    logic          gap_ok;
    logic          edge_m;
    logic          sck_q;
    logic          sync1_q, sync2_q, prev_q;

    assign gap_ok = (gap_q >= CW'(HALF_MIN - 1));
    assign edge_m = active_i && master_i && tick_i && gap_ok;
    assign sck_o  = sck_q;

    always_comb begin
        if (master_i) begin
            fall_o = edge_m && sck_q;
            rise_o = edge_m && !sck_q;
        end else begin
            fall_o = active_i && prev_q && !sync2_q;
            rise_o = active_i && !prev_q && sync2_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b1;
            gap_q   <= CW'(HALF_MIN - 1);
            sync1_q <= 1'b1;
            sync2_q <= 1'b1;
            prev_q  <= 1'b1;
        end else begin
            sync1_q <= sck_in_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
            if (!(master_i && active_i))
                sck_q <= 1'b1;
            else if (edge_m)
                sck_q <= ~sck_q;
            if (edge_m)
                gap_q <= '0;
            else if (!gap_ok)
                gap_q <= gap_q + 1'b1;
        end
    end

    // R5: with no transfer running the generated clock sits high
    p_idle_high_r5: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> sck_o);

endmodule

// File: rtl/sio_shifter.sv
module sio_shifter
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic [DATA_W-1:0] load_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o
);
    logic [DATA_W-1:0] shreg_q;
    logic [BIT_W-1:0]  bitcnt_q;
    logic              sdo_q;

    assign sdo_o  = sdo_q;
    assign done_o = rise_i && (bitcnt_q == BIT_W'(DATA_W - 1));
    assign rx_o   = {shreg_q[DATA_W-2:0], sdi_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
            sdo_q    <= 1'b1;
        end else if (fall_i) begin
            if (bitcnt_q == '0) begin
                shreg_q <= load_i;
                sdo_q   <= load_i[DATA_W-1];
            end else begin
                sdo_q   <= shreg_q[DATA_W-1];
            end
        end else if (rise_i) begin
            shreg_q  <= {shreg_q[DATA_W-2:0], sdi_i};
            bitcnt_q <= bitcnt_q + 1'b1;
        end
    end

    // R2: a rising edge never moves the output bit
    p_sdo_hold_r2: assert property (@(posedge clk) disable iff (rst)
        rise_i |=> $stable(sdo_o));

endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int HALF_MIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              irq
);
    localparam int PW = $clog2(HALF_MIN + 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic [IDX_W-1:0]  idx_q, last_q, sel_q, cnt_last_q;
    logic              fall_w, rise_w, done_w;
    logic [DATA_W-1:0] rx_w;
    reg_sel_e          rsel;

    assign rsel    = reg_sel_e'(reg_addr);
    assign sck_oe  = ctrl_q.master;
    assign irq     = stat_q.end_f;

    sio_clk_src #(.HALF_MIN(HALF_MIN)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .master_i (ctrl_q.master),
        .active_i (stat_q.busy),
        .tick_i   (tick),
        .sck_in_i (sck_in),
        .sck_o    (sck_out),
        .fall_o   (fall_w),
        .rise_o   (rise_w)
    );

    sio_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .fall_i (fall_w),
        .rise_i (rise_w),
        .load_i (mem_q[idx_q]),
        .sdi_i  (sdi),
        .sdo_o  (sdo),
        .done_o (done_w),
        .rx_o   (rx_w)
    );

    always_comb begin
        unique case (rsel)
            REG_DATA:  reg_rdata = mem_q[sel_q];
            REG_CTRL:  reg_rdata = pack_ctrl(ctrl_q);
            REG_COUNT: reg_rdata = {sel_q, cnt_last_q};
            REG_STAT:  reg_rdata = pack_stat(stat_q);
            default:   reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            ctrl_q     <= '0;
            stat_q     <= '0;
            idx_q      <= '0;
            last_q     <= '0;
            sel_q      <= '0;
            cnt_last_q <= '0;
        end else begin
            if (reg_we) begin
                unique case (rsel)
                    REG_DATA: if (!stat_q.busy) mem_q[sel_q] <= reg_wdata;
                    REG_CTRL: if (!stat_q.busy) begin
                        ctrl_q.master <= reg_wdata[CTRL_MASTER_BIT];
                        ctrl_q.burst  <= reg_wdata[CTRL_BURST_BIT];
                        if (reg_wdata[CTRL_GO_BIT]) begin
                            stat_q.busy <= 1'b1;
                            idx_q       <= '0;
                            last_q      <= reg_wdata[CTRL_BURST_BIT] ? cnt_last_q : '0;
                        end
                    end
                    REG_COUNT: if (!stat_q.busy) begin
                        cnt_last_q <= reg_wdata[IDX_W-1:0];
                        sel_q      <= reg_wdata[2*IDX_W-1:IDX_W];
                    end
                    REG_STAT: begin
                        if (reg_wdata[STAT_DONE_BIT]) stat_q.done_f <= 1'b0;
                        if (reg_wdata[STAT_END_BIT])  stat_q.end_f  <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (done_w) begin
                mem_q[idx_q]  <= rx_w;
                stat_q.done_f <= 1'b1;
                if (idx_q == last_q) begin
                    stat_q.busy  <= 1'b0;
                    stat_q.end_f <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // Phase-length monitor for the R4 property
    logic [PW-1:0] ph_len_q;
    logic          ph_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_len_q  <= PW'(HALF_MIN);
            ph_prev_q <= 1'b1;
        end else begin
            ph_prev_q <= sck_out;
            if (sck_out != ph_prev_q)
                ph_len_q <= PW'(1);
            else if (ph_len_q < PW'(HALF_MIN))
                ph_len_q <= ph_len_q + 1'b1;
        end
    end

    // R4: a driven clock level lasts at least HALF_MIN cycles
    p_phase_len_r4: assert property (@(posedge clk) disable iff (rst)
        sck_oe && (sck_out != ph_prev_q) |-> ph_len_q >= PW'(HALF_MIN));

    // R2: data out holds while the driven clock stays high
    p_sdo_stable_r2: assert property (@(posedge clk) disable iff (rst)
        sck_oe && sck_out && $past(sck_out) |-> $stable(sdo));

    // R8: interrupt appears only as the transfer finishes
    p_irq_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $fell(stat_q.busy));

endmodule

// File: tb/sio_port_test.sv
module sio_port_test;
    import sio_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tick = 1'b0;
    logic       sck_in = 1'b1;
    logic       sdi = 1'b1;
    logic       sck_out, sck_oe, sdo, irq;

    always #10 clk = ~clk;

    sio_port uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick(tick),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .sdi(sdi), .sdo(sdo), .irq(irq)
    );

    int errors = 0;
    int checks = 0;
    logic [7:0] ptx [16];
    logic [7:0] prx [16];
    int pidx = 0;
    int pbit = 0;
    int irq_rises = 0;
    logic tick_en = 1'b0;
    int tick_gap = 1;
    int tcnt = 0;
    int run_len = 0;
    int min_phase = 999;
    logic last_sck = 1'b1;

    wire line_clk = sck_oe ? sck_out : sck_in;

    // Peripheral model on the far end of the line
    always @(negedge line_clk) if (pidx < 16) sdi = ptx[pidx][7-pbit];
    always @(posedge line_clk) begin
        if (pidx < 16) begin
            prx[pidx][7-pbit] = sdo;
            if (pbit == 7) begin pbit = 0; pidx++; end
            else pbit++;
        end
    end

    always @(posedge irq) irq_rises++;

    initial forever begin
        @(negedge clk);
        tick = tick_en && (tcnt == 0);
        tcnt = (tcnt + 1 >= tick_gap) ? 0 : tcnt + 1;
    end

    initial forever begin
        @(negedge clk);
        if (sck_out !== last_sck) begin
            if (sck_oe && run_len < min_phase) min_phase = run_len;
            run_len = 1;
            last_sck = sck_out;
        end else run_len++;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(int lim);
        int n = 0;
        while (!irq && n < lim) begin @(negedge clk); n++; end
    endtask

    function automatic logic [7:0] vpat(int i);
        return 8'h1F + 8'(i * 8'h23);
    endfunction

    task automatic test_reset();
        logic [7:0] v;
        chk("R1 sck_out", sck_out, 1);
        chk("R1 sck_oe", sck_oe, 0);
        chk("R1 sdo", sdo, 1);
        chk("R1 irq", irq, 0);
        rd(REG_STAT, v);  chk("R1 stat", v, 8'h00);
        rd(REG_COUNT, v); chk("R1 count", v, 8'h00);
    endtask

    task automatic test_slave_idle();
        logic [7:0] v;
        wr(REG_DATA, 8'h5A);
        for (int k = 0; k < 3; k++) begin
            sck_in = 1'b0; wait_cycles(6);
            sck_in = 1'b1; wait_cycles(6);
        end
        pidx = 0; pbit = 0;
        chk("R12 sdo unchanged", sdo, 1);
        rd(REG_STAT, v); chk("R12 stat unchanged", v, 8'h00);
        rd(REG_DATA, v); chk("R12 slot0 unchanged", v, 8'h5A);
    endtask

    task automatic test_slave_xfer();
        logic [7:0] v;
        ptx[0] = 8'hC3;
        pidx = 0; pbit = 0;
        wr(REG_CTRL, 8'h04);
        chk("R6 slave oe", sck_oe, 0);
        rd(REG_STAT, v); chk("R9 busy", v, 8'h01);
        wr(REG_DATA, 8'hFF);
        wr(REG_COUNT, 8'h55);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk); sck_in = 1'b0;
            if (b == 0) begin
                wait_cycles(2); chk("R9 sdo before sync", sdo, 1);
                wait_cycles(1); chk("R9 sdo after sync", sdo, 0);
                wait_cycles(5);
            end else wait_cycles(8);
            sck_in = 1'b1; wait_cycles(8);
        end
        wait_cycles(6);
        chk("R2 slave tx msb first", prx[0], 8'h5A);
        rd(REG_COUNT, v); chk("R11 count write ignored", v, 8'h00);
        rd(REG_DATA, v);  chk("R3 R11 slot0 holds rx", v, 8'hC3);
        rd(REG_STAT, v);  chk("R9 stat end", v, 8'h06);
        chk("R9 irq", irq, 1);
        wr(REG_STAT, 8'h06);
    endtask

    task automatic test_master_single();
        logic [7:0] v;
        wr(REG_COUNT, 8'h03);
        wr(REG_DATA, 8'hA5);
        ptx[0] = 8'h3C; ptx[1] = 8'h99;
        pidx = 0; pbit = 0; min_phase = 999;
        tick_gap = 1; tick_en = 1'b1;
        wr(REG_CTRL, 8'h05);
        chk("R6 master oe", sck_oe, 1);
        wait_irq(2000);
        wait_cycles(2);
        chk("R2 master tx", prx[0], 8'hA5);
        chk("R7 one byte only", pidx, 1);
        rd(REG_DATA, v); chk("R3 master rx", v, 8'h3C);
        rd(REG_STAT, v); chk("R7 stat end", v, 8'h06);
        chk("R5 idle high", sck_out, 1);
        chk("R4 min phase", min_phase, 4);
        wait_cycles(30);
        chk("R5 ticks ignored idle", sck_out, 1);
        chk("R5 no extra bits", pbit, 0);
        wr(REG_STAT, 8'h06);
    endtask

    task automatic test_master_burst(int n, int gap);
        logic [7:0] v;
        int bad;
        wr(REG_STAT, 8'h06);
        for (int i = 0; i < n; i++) begin
            wr(REG_COUNT, {4'(i), 4'(n - 1)});
            wr(REG_DATA, vpat(i));
            ptx[i] = ~vpat(i) ^ 8'(i);
        end
        wr(REG_COUNT, {4'h0, 4'(n - 1)});
        pidx = 0; pbit = 0; irq_rises = 0; min_phase = 999;
        tick_gap = gap; tick_en = 1'b1;
        wr(REG_CTRL, 8'h07);
        begin
            int t = 0;
            while (pidx < 2 && t < 4000) begin @(negedge clk); t++; end
        end
        chk("R8 no irq mid burst", irq, 0);
        wait_irq(n * 40 * gap + 400);
        wait_cycles(2);
        chk("R8 irq once", irq_rises, 1);
        chk("R8 byte count", pidx, n);
        bad = 0;
        for (int i = 0; i < n; i++) if (prx[i] !== vpat(i)) bad++;
        chk("R8 tx order", bad, 0);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            wr(REG_COUNT, {4'(i), 4'(n - 1)});
            rd(REG_DATA, v);
            if (v !== ptx[i]) bad++;
        end
        chk("R3 rx slots", bad, 0);
        chk("R3 last slot", v, ptx[n-1]);
        chk("R4 phase len", min_phase, (gap < 4) ? 4 : gap);
        tick_en = 1'b0;
    endtask

    task automatic test_w1c();
        logic [7:0] v;
        rd(REG_STAT, v); chk("R10 stat set", v, 8'h06);
        wr(REG_STAT, 8'h02);
        rd(REG_STAT, v); chk("R10 clear done only", v, 8'h04);
        chk("R10 irq still set", irq, 1);
        wr(REG_STAT, 8'h04);
        rd(REG_STAT, v); chk("R10 clear end", v, 8'h00);
        chk("R10 irq cleared", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin ptx[i] = 8'h00; prx[i] = 8'h00; end
        wait_cycles(5);
        rst = 1'b0;
        wait_cycles(2);
        test_reset();
        test_slave_idle();
        test_slave_xfer();
        test_master_single();
        test_master_burst(4, 7);
        test_master_burst(16, 1);
        test_w1c();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule